// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming front end of one eight-input interrupt controller. Software reaches it through two byte ports: a command port and a data port, each with its own write strobe and its own read value. The block runs the four-word initialization sequence, decodes the operational commands, and holds the configuration that the rest of the controller reads: the interrupt mask, the vector base, the cascade wiring byte, the auto-EOI and rotate-on-auto-EOI flags, the special-mask and poll flags, the readback selection and the lowest-priority pointer.

The block does not capture request lines or scan priorities. It takes the current request and in-service vectors as inputs, only to return them on a command-port read and to choose the bit a non-specific end-of-interrupt clears. It drives two single-cycle controls toward that logic: a per-input clear-in-service vector and a reset request that is raised when an initialization start is accepted. Each initialization word is checked strictly. A word that asks for an unsupported mode is dropped, and the sequence stays where it was.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, init mode is off with step 1. The mask, vector base, cascade byte, every flag and the lowest-priority pointer are 0. The readback selection is the request vector, and both control outputs are low.
- R2: A command write of exactly 0x11 is the only accepted initialization start. One cycle later the block is in init mode with step 2, the mask cleared, the lowest-priority pointer at 7 and rotate-on-auto-EOI cleared. The reset request is high for that one cycle.
- R3: A command write with bit 4 set and any other value is rejected. It changes no state and raises no reset request.
- R4: In init mode a data write at step 2 loads the vector base and moves to step 3. A write at step 3 loads the cascade byte and moves to step 4. When the secondary input is high, a step-3 value above 0x07 is rejected and the step stays at 3.
- R5: At step 4, a data byte with bit 0 clear is rejected. If bit 0 and bit 1 are both set, auto-EOI is set and the step stays at 4. If bit 0 is set, bit 1 is clear and any of bits 7, 6, 5, 3 or 2 is set, the byte is rejected. Any other step-4 byte ends init mode and returns the step to 1.
- R6: Outside init mode a data write loads the mask. The data read value is always the mask.
- R7: A command write with bit 4 clear and bit 3 set is a mode command. When bit 1 is set, bit 0 selects the command-port readback: 1 selects the in-service input and 0 selects the request input. When bit 1 is clear, the selection is unchanged. The command read value follows the current selection.
- R8: In a mode command, bit 6 set loads the special-mask flag from bit 5, and bit 2 set raises the poll flag.
- R9: Command 0x20 pulses the clear-in-service output for one cycle on the lowest-numbered set bit of the in-service input, and pulses nothing when that input is zero. Commands 0x21 to 0x27 have no effect.
- R10: Command 0x60+n (n = 0..7) pulses bit n of the clear-in-service output for one cycle.
- R11: Commands 0xA0 and 0xE0+n act as 0x20 and 0x60+n, and also add 1 to the lowest-priority pointer, wrapping from 7 to 0.
- R12: Command 0xC0+n loads n into the lowest-priority pointer. 0x80 sets rotate-on-auto-EOI, 0x00 clears it, and 0x40 changes nothing.
- R13: When both strobes are high in the same cycle, only the command write takes effect and the data byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| secondary | input | 1 | High when this controller sits behind another one |
| cmd_we | input | 1 | Command-port write strobe |
| data_we | input | 1 | Data-port write strobe |
| wdata | input | 8 | Write byte for either port |
| irr_in | input | 8 | Current request vector |
| isr_in | input | 8 | Current in-service vector |
| cmd_rdata | output | 8 | Command-port read value |
| data_rdata | output | 8 | Data-port read value (mask) |
| init_busy | output | 1 | Init sequence in progress |
| init_step | output | 3 | Next expected init word (1 when idle) |
| irq_mask | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base |
| cascade_cfg | output | 8 | Cascade wiring byte |
| auto_eoi | output | 1 | Auto-EOI enabled |
| rot_aeoi | output | 1 | Rotate on auto-EOI |
| special_mask | output | 1 | Special-mask mode |
| poll_req | output | 1 | Poll flag |
| low_pri | output | 3 | Lowest-priority input index |
| isr_clr | output | 8 | One-cycle clear-in-service pulse |
| reset_req | output | 1 | One-cycle state-reset request |

## Verification
Directed sequences first send every rejected form of the start byte and of the step-4 byte. They then repeat the step-3 write with the secondary input both low and high, which separates a validation that leaves state alone from one that only skips the advance. EOI commands are applied with several in-service patterns, including zero and multi-bit vectors, to tell the lowest-bit choice apart from the index choice. Rotates are issued at pointer 7 to expose the wrap. A long stretch of random strobes, bytes and input vectors then exercises command/data overlap and writes made while in init mode.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
    localparam int BYTE_W = 8;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int STEP_W = 3;

    localparam logic [STEP_W-1:0] STEP_IDLE = 3'd1;
    localparam logic [STEP_W-1:0] STEP_VEC  = 3'd2;
    localparam logic [STEP_W-1:0] STEP_CAS  = 3'd3;
    localparam logic [STEP_W-1:0] STEP_MODE = 3'd4;

    // registered state of the decoder
    typedef struct packed {
        logic                init_busy;
        logic [STEP_W-1:0]   step;
        logic [BYTE_W-1:0]   mask;
        logic [BYTE_W-1:0]   vbase;
        logic [BYTE_W-1:0]   cascade;
        logic                aeoi;
        logic                rot_aeoi;
        logic                smm;
        logic                poll;
        logic                rd_isr;
        logic [IDX_W-1:0]    low_pri;
        logic [LINES-1:0]    isr_clr;
        logic                reset_req;
    } ctl_state_t;

    // classified command-port byte
    typedef struct packed {
        logic start_ok;
        logic sel_upd;
        logic sel_isr;
        logic smm_upd;
        logic smm_val;
        logic poll_set;
        logic eoi_any;
        logic eoi_specific;
        logic eoi_rotate;
        logic set_pri;
        logic rot_set;
        logic rot_clr;
    } cmd_dec_t;
endpackage

// File: rtl/pic_cmd_classify.sv
module pic_cmd_classify
    import pic_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_dec_t          dec
);
    always_comb begin
        dec = '0;
        if (cmd_byte[4]) begin
            // start word: needs the fourth-word request, nothing unsupported
            dec.start_ok = cmd_byte[0] && !cmd_byte[1] && !cmd_byte[2] &&
                           !cmd_byte[3] && (cmd_byte[7:5] == 3'b000);
        end else if (cmd_byte[3]) begin
            dec.sel_upd  = cmd_byte[1];
            dec.sel_isr  = cmd_byte[0];
            dec.smm_upd  = cmd_byte[6];
            dec.smm_val  = cmd_byte[5];
            dec.poll_set = cmd_byte[2];
        end else if (cmd_byte[5]) begin
            // non-specific forms only with a zero index field
            if (cmd_byte[6] || (cmd_byte[2:0] == 3'b000)) begin
                dec.eoi_any      = 1'b1;
                dec.eoi_specific = cmd_byte[6];
                dec.eoi_rotate   = cmd_byte[7];
            end
        end else begin
            case (cmd_byte[7:6])
                2'b11:   dec.set_pri = 1'b1;
                2'b10:   dec.rot_set = (cmd_byte[2:0] == 3'b000);
                2'b00:   dec.rot_clr = (cmd_byte[2:0] == 3'b000);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_init_word_check.sv
module pic_init_word_check
    import pic_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] word,
    input  logic [STEP_W-1:0] step,
    input  logic              secondary,
    output logic              word_ok,
    output logic              aeoi_hit
);
    always_comb begin
        word_ok  = 1'b0;
        aeoi_hit = 1'b0;
        case (step)
            STEP_VEC: word_ok = 1'b1;
            STEP_CAS: word_ok = !(secondary && (word[7:3] != 5'b0));
            STEP_MODE: begin
                if (!word[0]) begin
                    word_ok = 1'b0;
                end else if (word[1]) begin
                    aeoi_hit = 1'b1;
                end else begin
                    word_ok = !word[2] && !word[3] && (word[7:5] == 3'b000);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pic_lowest_bit.sv
module pic_lowest_bit #(
    parameter int N = 8
) (
    input  logic [N-1:0] vec,
    output logic [N-1:0] onehot
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_scan
        assign onehot[i]  = vec[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | vec[i];
    end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              secondary,
    input  logic              cmd_we,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] irr_in,
    input  logic [BYTE_W-1:0] isr_in,
    output logic [BYTE_W-1:0] cmd_rdata,
    output logic [BYTE_W-1:0] data_rdata,
    output logic              init_busy,
    output logic [STEP_W-1:0] init_step,
    output logic [BYTE_W-1:0] irq_mask,
    output logic [BYTE_W-1:0] vec_base,
    output logic [BYTE_W-1:0] cascade_cfg,
    output logic              auto_eoi,
    output logic              rot_aeoi,
    output logic              special_mask,
    output logic              poll_req,
    output logic [IDX_W-1:0]  low_pri,
    output logic [LINES-1:0]  isr_clr,
    output logic              reset_req
);
    ctl_state_t s_q, s_d;
    cmd_dec_t   dec;
    logic       word_ok, aeoi_hit;
    logic [LINES-1:0] low_1h, spec_1h;

    pic_cmd_classify u_classify (
        .cmd_byte (wdata),
        .dec      (dec)
    );

    pic_init_word_check u_word_check (
        .word      (wdata),
        .step      (s_q.step),
        .secondary (secondary),
        .word_ok   (word_ok),
        .aeoi_hit  (aeoi_hit)
    );

    pic_lowest_bit #(.N(LINES)) u_lowest (
        .vec    (isr_in[LINES-1:0]),
        .onehot (low_1h)
    );

    assign spec_1h = {{(LINES-1){1'b0}}, 1'b1} << wdata[IDX_W-1:0];

    always_comb begin
        s_d           = s_q;
        s_d.isr_clr   = '0;
        s_d.reset_req = 1'b0;
        if (cmd_we) begin
            if (dec.start_ok) begin
                s_d.init_busy = 1'b1;
                s_d.step      = STEP_VEC;
                s_d.mask      = '0;
                s_d.low_pri   = '1;
                s_d.rot_aeoi  = 1'b0;
                s_d.reset_req = 1'b1;
            end
            if (dec.sel_upd)  s_d.rd_isr = dec.sel_isr;
            if (dec.smm_upd)  s_d.smm    = dec.smm_val;
            if (dec.poll_set) s_d.poll   = 1'b1;
            if (dec.eoi_any) begin
                s_d.isr_clr = dec.eoi_specific ? spec_1h : low_1h;
                if (dec.eoi_rotate) s_d.low_pri = s_q.low_pri + IDX_W'(1);
            end
            if (dec.set_pri) s_d.low_pri  = wdata[IDX_W-1:0];
            if (dec.rot_set) s_d.rot_aeoi = 1'b1;
            if (dec.rot_clr) s_d.rot_aeoi = 1'b0;
        end else if (data_we) begin
            if (s_q.init_busy) begin
                case (s_q.step)
                    STEP_VEC:  s_d.vbase = wdata;
                    STEP_CAS:  if (word_ok) s_d.cascade = wdata;
                    STEP_MODE: if (aeoi_hit) s_d.aeoi = 1'b1;
                    default: ;
                endcase
                if (word_ok) begin
                    if (s_q.step == STEP_MODE) begin
                        s_d.init_busy = 1'b0;
                        s_d.step      = STEP_IDLE;
                    end else begin
                        s_d.step = s_q.step + STEP_W'(1);
                    end
                end
            end else begin
                s_d.mask = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.step <= STEP_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_rdata    = s_q.rd_isr ? isr_in : irr_in;
    assign data_rdata   = s_q.mask;
    assign init_busy    = s_q.init_busy;
    assign init_step    = s_q.step;
    assign irq_mask     = s_q.mask;
    assign vec_base     = s_q.vbase;
    assign cascade_cfg  = s_q.cascade;
    assign auto_eoi     = s_q.aeoi;
    assign rot_aeoi     = s_q.rot_aeoi;
    assign special_mask = s_q.smm;
    assign poll_req     = s_q.poll;
    assign low_pri      = s_q.low_pri;
    assign isr_clr      = s_q.isr_clr;
    assign reset_req    = s_q.reset_req;
endmodule

// File: rtl/pic_cmd_checker.sv
module pic_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       secondary,
    input logic       cmd_we,
    input logic       data_we,
    input logic [7:0] wdata,
    input logic       init_busy,
    input logic [2:0] init_step,
    input logic [7:0] irq_mask,
    input logic [2:0] low_pri,
    input logic       rot_aeoi,
    input logic [7:0] isr_clr,
    input logic       reset_req
);
    assert_idle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_busy |-> init_step == 3'd1);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (irq_mask == 8'h00 && low_pri == 3'd7 && init_busy &&
                       init_step == 3'd2 && !rot_aeoi));

    assert_secondary_word3_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !cmd_we && init_busy && init_step == 3'd3 && secondary &&
         wdata[7:3] != 5'b0) |=> init_step == 3'd3);

    assert_busy_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> (init_step >= 3'd2 && init_step <= 3'd4));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !cmd_we && !init_busy) |=> irq_mask == $past(wdata));

    assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_clr));

    assert_nop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wdata == 8'h40) |=> ($stable(low_pri) && $stable(irq_mask) &&
                                        $stable(rot_aeoi) && isr_clr == 8'h00 && !reset_req));
endmodule

bind pic_cmd_decoder pic_cmd_checker u_pic_cmd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .secondary (secondary),
    .cmd_we    (cmd_we),
    .data_we   (data_we),
    .wdata     (wdata),
    .init_busy (init_busy),
    .init_step (init_step),
    .irq_mask  (irq_mask),
    .low_pri   (low_pri),
    .rot_aeoi  (rot_aeoi),
    .isr_clr   (isr_clr),
    .reset_req (reset_req)
);

// File: tb/tb_pic_cmd_decoder.sv
`timescale 1ns/1ps
module tb_pic_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       secondary = 1'b0;
    logic       cmd_we = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] irr_in = 8'h00;
    logic [7:0] isr_in = 8'h00;
    logic [7:0] cmd_rdata, data_rdata, irq_mask, vec_base, cascade_cfg, isr_clr;
    logic       init_busy, auto_eoi, rot_aeoi, special_mask, poll_req, reset_req;
    logic [2:0] init_step, low_pri;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_init, m_step, m_mask, m_vb, m_cas, m_aeoi, m_rot, m_smm, m_poll, m_sel, m_low, m_clr, m_rst;

    always #2.5 clk = ~clk;

    pic_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .secondary(secondary), .cmd_we(cmd_we),
        .data_we(data_we), .wdata(wdata), .irr_in(irr_in), .isr_in(isr_in),
        .cmd_rdata(cmd_rdata), .data_rdata(data_rdata), .init_busy(init_busy),
        .init_step(init_step), .irq_mask(irq_mask), .vec_base(vec_base),
        .cascade_cfg(cascade_cfg), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
        .special_mask(special_mask), .poll_req(poll_req), .low_pri(low_pri),
        .isr_clr(isr_clr), .reset_req(reset_req)
    );

    task automatic model_reset();
        m_init = 0; m_step = 1; m_mask = 0; m_vb = 0; m_cas = 0; m_aeoi = 0;
        m_rot = 0; m_smm = 0; m_poll = 0; m_sel = 0; m_low = 0; m_clr = 0; m_rst = 0;
    endtask

    task automatic model_step(input bit c, input bit d, input int b);
        m_clr = 0;
        m_rst = 0;
        if (c) begin
            if (b == 8'h11) begin
                m_init = 1; m_step = 2; m_mask = 0; m_low = 7; m_rot = 0; m_rst = 1;
            end else if ((b / 16) % 2 == 1) begin
                // rejected start word
            end else if ((b / 8) % 2 == 1) begin
                if ((b / 2) % 2 == 1) m_sel = b % 2;
                if ((b / 64) % 2 == 1) m_smm = (b / 32) % 2;
                if ((b / 4) % 2 == 1) m_poll = 1;
            end else if (b == 8'h20 || b == 8'hA0) begin
                for (int i = 7; i >= 0; i--) if (isr_in[i]) m_clr = 1 << i;
                if (b == 8'hA0) m_low = (m_low + 1) % 8;
            end else if ((b >= 8'h60 && b <= 8'h67) || (b >= 8'hE0 && b <= 8'hE7)) begin
                m_clr = 1 << (b % 8);
                if (b >= 8'hE0) m_low = (m_low + 1) % 8;
            end else if (b >= 8'hC0 && b <= 8'hC7) begin
                m_low = b - 8'hC0;
            end else if (b == 8'h80) begin
                m_rot = 1;
            end else if (b == 8'h00) begin
                m_rot = 0;
            end
        end else if (d) begin
            if (m_init == 0) begin
                m_mask = b;
            end else if (m_step == 2) begin
                m_vb = b; m_step = 3;
            end else if (m_step == 3) begin
                if (!(secondary && b > 7)) begin m_cas = b; m_step = 4; end
            end else if (m_step == 4) begin
                if (b % 2 == 0) begin
                end else if ((b / 2) % 2 == 1) begin
                    m_aeoi = 1;
                end else if ((b & 8'hEC) == 0) begin
                    m_init = 0; m_step = 1;
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "init_busy", int'(init_busy), m_init);
        chk(req, "init_step", int'(init_step), m_step);
        chk(req, "irq_mask", int'(irq_mask), m_mask);
        chk(req, "data_rdata", int'(data_rdata), m_mask);
        chk(req, "vec_base", int'(vec_base), m_vb);
        chk(req, "cascade_cfg", int'(cascade_cfg), m_cas);
        chk(req, "auto_eoi", int'(auto_eoi), m_aeoi);
        chk(req, "rot_aeoi", int'(rot_aeoi), m_rot);
        chk(req, "special_mask", int'(special_mask), m_smm);
        chk(req, "poll_req", int'(poll_req), m_poll);
        chk(req, "low_pri", int'(low_pri), m_low);
        chk(req, "isr_clr", int'(isr_clr), m_clr);
        chk(req, "reset_req", int'(reset_req), m_rst);
        chk(req, "cmd_rdata", int'(cmd_rdata), m_sel ? int'(isr_in) : int'(irr_in));
    endtask

    task automatic tick(input string req, input bit c, input bit d, input logic [7:0] b);
        @(negedge clk);
        cmd_we = c; data_we = d; wdata = b;
        @(posedge clk);
        #1;
        model_step(c, d, int'(b));
        cmd_we = 1'b0; data_we = 1'b0;
        compare_all(req);
    endtask

    task automatic cmd(input string req, input logic [7:0] b);
        tick(req, 1'b1, 1'b0, b);
        tick(req, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic dat(input string req, input logic [7:0] b);
        tick(req, 1'b0, 1'b1, b);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R1");
        tick("R1", 1'b0, 1'b0, 8'h00);

        // R6 mask load and readback
        dat("R6", 8'h5A);
        dat("R6", 8'hA5);

        // R7 readback selection
        irr_in = 8'h12; isr_in = 8'h84;
        tick("R7", 1'b0, 1'b0, 8'h00);
        cmd("R7", 8'h0B);
        cmd("R7", 8'h09);
        cmd("R7", 8'h0A);
        cmd("R7", 8'h0B);
        cmd("R7", 8'h08);

        // R8 special mask and poll
        cmd("R8", 8'h68);
        cmd("R8", 8'h28);
        cmd("R8", 8'h48);
        cmd("R8", 8'h0C);

        // R12 settings that a start word must clear
        cmd("R12", 8'h80);
        cmd("R12", 8'hC3);
        cmd("R12", 8'h40);

        // R3 rejected start words
        cmd("R3", 8'h10);
        cmd("R3", 8'h13);
        cmd("R3", 8'h15);
        cmd("R3", 8'h19);
        cmd("R3", 8'h31);
        cmd("R3", 8'hF1);

        // R2 accepted start
        tick("R2", 1'b1, 1'b0, 8'h11);
        tick("R2", 1'b0, 1'b0, 8'h00);

        // R4 vector base and cascade (primary)
        dat("R4", 8'h20);
        dat("R4", 8'h04);

        // R5 mode word rules
        dat("R5", 8'h00);
        dat("R5", 8'h05);
        dat("R5", 8'h09);
        dat("R5", 8'h21);
        dat("R5", 8'h81);
        dat("R5", 8'h03);
        dat("R5", 8'h11);

        // R4 secondary cascade validation
        secondary = 1'b1;
        cmd("R4", 8'h11);
        dat("R4", 8'h70);
        dat("R4", 8'h08);
        dat("R4", 8'hF2);
        dat("R4", 8'h02);
        dat("R5", 8'h01);
        secondary = 1'b0;

        // R9 non-specific end of interrupt
        isr_in = 8'h28;
        cmd("R9", 8'h20);
        isr_in = 8'h81;
        cmd("R9", 8'h20);
        isr_in = 8'h00;
        cmd("R9", 8'h20);
        isr_in = 8'hFF;
        cmd("R9", 8'h23);
        cmd("R9", 8'h27);

        // R10 specific end of interrupt
        cmd("R10", 8'h65);
        cmd("R10", 8'h60);
        cmd("R10", 8'h67);

        // R11 rotating forms with wrap
        cmd("R12", 8'hC6);
        isr_in = 8'h50;
        cmd("R11", 8'hA0);
        cmd("R11", 8'hE2);
        cmd("R11", 8'hE7);

        // R12 priority and rotate flags
        cmd("R12", 8'hC5);
        cmd("R12", 8'h80);
        cmd("R12", 8'h40);
        cmd("R12", 8'h00);
        cmd("R12", 8'h85);

        // R13 simultaneous strobes
        tick("R13", 1'b1, 1'b1, 8'hC2);
        tick("R13", 1'b1, 1'b1, 8'h0B);

        // mixed traffic covering R1 to R13 together
        for (int k = 0; k < 600; k++) begin
            logic [7:0] rb;
            int sel;
            rb = 8'($urandom);
            sel = int'($urandom % 8);
            if (k % 50 == 0) rb = 8'h11;
            irr_in = 8'($urandom);
            isr_in = (k % 7 == 0) ? 8'h00 : 8'($urandom);
            secondary = (k % 3 == 0);
            tick("R13", sel == 0 || sel == 1 || sel == 6, sel == 2 || sel == 3 || sel == 6, rb);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule